// File: doc/BRIEF.md
# Clock Divider Bank with Per-Field Busy Status

This block produces ten divided clock enables from a single input clock for a processor clock domain. The ratio of each divider is set through a small register port. A main control word carries eight ratio fields and an auxiliary control word carries two more. Each field holds a 3-bit value N, and its divider then emits a one-cycle enable pulse every N+1 input cycles. A value of 0 gives an enable on every cycle.

New ratios are not applied at once. A written value waits in a programmed register until its divider reaches terminal count. The divider then reloads with the new ratio, so the spacing between pulses is always either the old period or the new one. Each field has a busy flag that stays set while its new ratio is pending. Software or a sequencer polls the two status words until they read zero before it moves on. Writes to the auxiliary word are accepted only when no field of the main word is busy. This enforces the required ordering: main dividers first, then auxiliary dividers.

Top module: `clkdiv_bank`

## Requirements
- R1: After a synchronous active-low reset, all ten ratios, both control words and both status words read zero, and every enable output is high on every cycle.
- R2: A write with `wr_sel`=0 loads field k (k=0..7) from `wr_data[4k+2:4k]`. With `rd_sel`=0 these fields read back at the same positions. All other bits of the word read zero and ignore written data.
- R3: A write with `wr_sel`=1 loads field 8 from `wr_data[2:0]` and field 9 from `wr_data[6:4]`. With `rd_sel`=1 they read back at those positions, and all other bits read zero.
- R4: Once a ratio N is in effect, `div_en[k]` is high for one cycle in every N+1 cycles. Fields 0..7 drive `div_en[7:0]` and fields 8, 9 drive `div_en[9:8]`.
- R5: From the cycle after a write that changes a field, that field's busy bit reads 1. With `rd_sel`=2, field k's busy bit sits at bit 4k. With `rd_sel`=3, fields 8 and 9 sit at bits 0 and 4. A write that leaves a field's value unchanged does not set its busy bit.
- R6: A pending ratio takes effect only when its divider passes terminal count, and its busy bit clears at that point. Every gap between pulses equals either the old period or the new one.
- R7: A write to the auxiliary word is dropped if any main-word busy bit is set in that cycle.
- R8: If a write lands on the same cycle as terminal count, that terminal count reloads the old ratio. The new ratio takes effect at the following terminal count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 1 | 0 selects the main control word, 1 the auxiliary word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | 0 main control, 1 auxiliary control, 2 main status, 3 auxiliary status |
| rd_data | output | 32 | Read data for the selected word, combinational |
| div_en | output | 10 | Divided clock enable pulses, one per field |

## Verification
A ratio write and the terminal count of that same divider can occur in the same cycle. The write updates the programmed value while the counter reloads with the previous one. The bench provokes this by waiting for a pulse on one divider, then driving a changed ratio into the cycle in which that pulse is high. It then expects one more gap at the old period, the busy bit set across that gap, and the new period after it. A second overlap is also exercised: an auxiliary write issued in the cycle straight after a main-word change, while the main word is still busy. Its readback must remain unchanged.

// File: rtl/clkdiv_pkg.sv
// Shared constants and read-select encoding for the clock divider bank.
package clkdiv_pkg;
    localparam int FIELD_W     = 3;   // bits per ratio field
    localparam int FIELD_PITCH = 4;   // bit distance between fields in a word
    localparam int N_PRI       = 8;   // fields in the main control word
    localparam int N_SEC       = 2;   // fields in the auxiliary control word
    localparam int WORD_W      = 32;  // register word width

    typedef enum logic [1:0] {
        RD_PRI_CTRL = 2'd0,
        RD_SEC_CTRL = 2'd1,
        RD_PRI_STAT = 2'd2,
        RD_SEC_STAT = 2'd3
    } rd_sel_e;
endpackage

// File: rtl/clkdiv_unit.sv
// One divider: holds a programmed ratio and an active ratio.
// Counts 0..active and pulses at terminal count.
// Copies programmed into active only at terminal count.
// Busy is the mismatch between the two values.
// Assumes load_i is a single-cycle write strobe for this field.
module clkdiv_unit #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [DIV_W-1:0] ratio_i,
    output logic [DIV_W-1:0] prog_o,
    output logic             busy_o,
    output logic             pulse_o
);
    logic [DIV_W-1:0] prog_q;
    logic [DIV_W-1:0] cur_q;
    logic [DIV_W-1:0] cnt_q;

    assign pulse_o = (cnt_q == cur_q);
    assign busy_o  = (prog_q != cur_q);
    assign prog_o  = prog_q;

    // Capture the written ratio as the pending value.
    always_ff @(posedge clk) begin
        if (!rst_n)      prog_q <= '0;
        else if (load_i) prog_q <= ratio_i;
    end

    // Count to the active ratio, then reload and adopt the pending ratio.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cur_q <= '0;
        end else if (pulse_o) begin
            cnt_q <= '0;
            cur_q <= prog_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6: the active ratio may only change on a terminal-count cycle.
    assert_ratio_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q != $past(cur_q)) |-> $past(pulse_o));

    // R6: a pending change with no new write clears at terminal count.
    assert_busy_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && pulse_o && !load_i) |=> !busy_o);

    // R5: a changing write makes the field busy on the next cycle.
    assert_busy_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (ratio_i != prog_q) && (ratio_i != cur_q)) |=> busy_o);

    // R4: the counter restarts from zero after each pulse.
    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> (cnt_q == '0));
endmodule

// File: rtl/clkdiv_readmux.sv
// Packs the programmed ratios and busy flags into the four readable words.
// Fields sit every PITCH bits, and unused bits read zero.
module clkdiv_readmux #(
    parameter int DIV_W  = 3,
    parameter int PITCH  = 4,
    parameter int N_PRI  = 8,
    parameter int N_SEC  = 2,
    parameter int WORD_W = 32,
    localparam int N_TOT = N_PRI + N_SEC
) (
    input  logic [1:0]             rd_sel,
    input  logic [N_TOT*DIV_W-1:0] prog_i,
    input  logic [N_TOT-1:0]       busy_i,
    output logic [WORD_W-1:0]      rd_data
);
    import clkdiv_pkg::*;

    logic [WORD_W-1:0] pri_ctrl, sec_ctrl, pri_stat, sec_stat;

    // Place each field's ratio and busy flag at its word position.
    always_comb begin
        pri_ctrl = '0;
        sec_ctrl = '0;
        pri_stat = '0;
        sec_stat = '0;
        for (int k = 0; k < N_PRI; k++) begin
            pri_ctrl[k*PITCH +: DIV_W] = prog_i[k*DIV_W +: DIV_W];
            pri_stat[k*PITCH]          = busy_i[k];
        end
        for (int j = 0; j < N_SEC; j++) begin
            sec_ctrl[j*PITCH +: DIV_W] = prog_i[(N_PRI+j)*DIV_W +: DIV_W];
            sec_stat[j*PITCH]          = busy_i[N_PRI+j];
        end
    end

    // Select the word requested by the read port.
    always_comb begin
        case (rd_sel_e'(rd_sel))
            RD_PRI_CTRL: rd_data = pri_ctrl;
            RD_SEC_CTRL: rd_data = sec_ctrl;
            RD_PRI_STAT: rd_data = pri_stat;
            default:     rd_data = sec_stat;
        endcase
    end
endmodule

// File: rtl/clkdiv_bank.sv
// Top of the divider bank: ten dividers fed from two control words.
// Auxiliary writes are dropped while any main field is busy.
// Assumes a single clock, and that the write port is sampled on its rising edge.
module clkdiv_bank #(
    parameter int DIV_W  = clkdiv_pkg::FIELD_W,
    parameter int PITCH  = clkdiv_pkg::FIELD_PITCH,
    parameter int N_PRI  = clkdiv_pkg::N_PRI,
    parameter int N_SEC  = clkdiv_pkg::N_SEC,
    parameter int WORD_W = clkdiv_pkg::WORD_W,
    localparam int N_TOT = N_PRI + N_SEC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [1:0]        rd_sel,
    output logic [WORD_W-1:0] rd_data,
    output logic [N_TOT-1:0]  div_en
);
    logic [N_TOT*DIV_W-1:0] prog;
    logic [N_TOT-1:0]       busy;
    logic                   pri_ld;
    logic                   sec_ld;

    // Decode write strobes, guarding the auxiliary word behind main-word busy.
    always_comb begin
        pri_ld = wr_en && !wr_sel;
        sec_ld = wr_en && wr_sel && !(|busy[N_PRI-1:0]);
    end

    for (genvar k = 0; k < N_TOT; k++) begin : g_div
        localparam int OFS = (k < N_PRI) ? k*PITCH : (k-N_PRI)*PITCH;
        clkdiv_unit #(.DIV_W(DIV_W)) u_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  ((k < N_PRI) ? pri_ld : sec_ld),
            .ratio_i (wr_data[OFS +: DIV_W]),
            .prog_o  (prog[k*DIV_W +: DIV_W]),
            .busy_o  (busy[k]),
            .pulse_o (div_en[k])
        );
    end

    clkdiv_readmux #(
        .DIV_W(DIV_W), .PITCH(PITCH), .N_PRI(N_PRI), .N_SEC(N_SEC), .WORD_W(WORD_W)
    ) u_rd (
        .rd_sel  (rd_sel),
        .prog_i  (prog),
        .busy_i  (busy),
        .rd_data (rd_data)
    );

    // R7: an auxiliary write during main-word busy leaves the auxiliary ratios unchanged.
    assert_sec_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel && (|busy[N_PRI-1:0]))
        |=> (prog[N_TOT*DIV_W-1:N_PRI*DIV_W] == $past(prog[N_TOT*DIV_W-1:N_PRI*DIV_W])));
endmodule

// File: tb/test_clkdiv_bank.sv
// Directed bench for the divider bank. Inputs are driven and outputs sampled at the falling edge.
module test_clkdiv_bank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic [9:0]  div_en;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    clkdiv_bank i_clkdiv_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .div_en(div_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 50000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] val);
        rd_sel = sel;
        #1;
        val = rd_data;
    endtask

    // Caller is at a falling edge; write lands on the next rising edge.
    task automatic do_write(input logic sel, input logic [31:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle(input logic [1:0] stat_sel);
        logic [31:0] v;
        for (int i = 0; i < 64; i++) begin
            rd(stat_sel, v);
            if (v == 0) return;
            @(negedge clk);
        end
    endtask

    // Returns the number of cycles between two consecutive pulses on field idx.
    task automatic gap(input int idx, output int g);
        g = 0;
        for (int i = 0; i < 64 && !div_en[idx]; i++) @(negedge clk);
        for (int i = 1; i < 64; i++) begin
            @(negedge clk);
            if (div_en[idx]) begin g = i; return; end
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 4; s++) begin
            rd(s[1:0], v);
            check("R1 reset word", v, 32'h0);
        end
        for (int c = 0; c < 3; c++) begin
            check("R1 enables every cycle", {22'h0, div_en}, 32'h3FF);
            @(negedge clk);
        end
    endtask

    task automatic t_main_layout();
        logic [31:0] v;
        int g;
        do_write(1'b0, 32'hFFFF_FFFF);
        rd(2'd0, v); check("R2 readback masks unused bits", v, 32'h7777_7777);
        rd(2'd2, v); check("R5 all main busy after change", v, 32'h1111_1111);
        @(negedge clk);
        rd(2'd2, v); check("R6 ratio-0 dividers adopt at next edge", v, 32'h0);
        gap(0, g); check("R4 field0 ratio 7", g, 8);
        gap(7, g); check("R4 field7 ratio 7", g, 8);
    endtask

    task automatic t_distinct();
        logic [31:0] v;
        int g;
        do_write(1'b0, 32'h0123_4567);
        rd(2'd0, v); check("R2 distinct readback", v, 32'h0123_4567);
        rd(2'd2, v); check("R5 unchanged field0 not busy", v, 32'h1111_1110);
        wait_idle(2'd2);
        rd(2'd2, v); check("R6 busy clears", v, 32'h0);
        for (int k = 0; k < 8; k++) begin
            gap(k, g); check("R4 per-field period", g, 8 - k);
        end
    endtask

    task automatic t_sec_guard();
        logic [31:0] v;
        int g;
        do_write(1'b0, 32'h0123_4562);
        do_write(1'b1, 32'h0000_0035);
        rd(2'd1, v); check("R7 aux write dropped while main busy", v, 32'h0);
        rd(2'd3, v); check("R7 aux status idle", v, 32'h0);
        wait_idle(2'd2);
        do_write(1'b1, 32'hFFFF_FF35);
        rd(2'd1, v); check("R3 aux readback", v, 32'h0000_0035);
        rd(2'd3, v); check("R5 aux busy", v, 32'h0000_0011);
        wait_idle(2'd3);
        gap(8, g); check("R3 field8 ratio 5", g, 6);
        gap(9, g); check("R3 field9 ratio 3", g, 4);
    endtask

    task automatic t_spacing();
        logic [31:0] v;
        int last = -1;
        int bad = 0;
        int g;
        do_write(1'b0, 32'h0123_4512);
        for (int c = 0; c < 30; c++) begin
            if (div_en[1]) begin
                if (last >= 0 && (c - last) != 7 && (c - last) != 2) bad++;
                last = c;
            end
            @(negedge clk);
        end
        check("R6 gaps only old or new", bad, 0);
        rd(2'd2, v); check("R6 busy cleared after change", v, 32'h0);
        gap(1, g); check("R4 field1 new ratio 1", g, 2);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        int g;
        for (int i = 0; i < 64 && !div_en[2]; i++) @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 32'h0123_4112;
        @(negedge clk);
        wr_en = 1'b0;
        rd(2'd2, v); check("R8 busy after write on terminal", v, 32'h0000_0100);
        g = 1;
        for (int i = 0; i < 64 && !div_en[2]; i++) begin @(negedge clk); g++; end
        check("R8 one more old period", g, 6);
        gap(2, g); check("R8 new period next", g, 2);
        rd(2'd2, v); check("R8 busy clear after adoption", v, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_main_layout();
        t_distinct();
        t_sec_guard();
        t_spacing();
        t_collision();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule